// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block holds a small set of virtual-to-physical page translations and answers lookups in the same cycle. Every slot stores a virtual page number, a physical page number, an address-space tag, a shared-page flag, per-privilege-mode read and write permission masks, and two fault-on-access flags. A lookup presents a page number together with the current address-space tag. It returns whether a slot hit, which slot it was, and the fields stored in that slot.

New translations are written through an insert port. The slot that receives them is always the one named by a round-robin victim pointer, and the pointer then moves on. Three invalidation commands come in on a two-bit flush port: drop everything, drop only the per-process slots, or drop the slots that would hit for one page and address-space tag. Page-table walking and the checking of permissions are left to the logic that uses this block.

Top module: `tlb_assoc`

## Requirements
- R1: A lookup hits only when a slot is valid, its tag equals `lk_vpn`, and either its shared flag is set or its stored address-space tag equals `lk_asn`. The result appears combinationally in the same cycle and reflects the table as of the last clock edge.
- R2: An insert (`ins_valid`=1 while `flush_cmd`=0) writes the slot named by the victim pointer and marks it valid. The pointer then advances by one. Inserting a page never checks whether that page is already present.
- R3: `flush_cmd`=1 clears every valid bit and returns the victim pointer to slot 0.
- R4: `flush_cmd`=2 invalidates every slot whose shared flag is clear and keeps shared slots.
- R5: `flush_cmd`=3 invalidates every slot that a lookup of (`flush_vaddr` page, `flush_asn`) would hit, using the R1 rule. Other slots are kept.
- R6: After an insert into slot DEPTH-1, the victim pointer wraps to slot 0.
- R7: On a hit, `lk_ppn`, `lk_rd_en`, `lk_wr_en`, `lk_fault_rd`, `lk_fault_wr` and `lk_global` carry the fields stored in the hitting slot. On a miss, all of these outputs and `lk_index` are zero.
- R8: When several slots hit, `lk_index` names the lowest-numbered one.
- R9: After reset, no slot is valid and the victim pointer is 0.
- R10: When an insert and a non-zero flush command arrive in the same cycle, the flush is performed and the insert is dropped. The victim pointer does not advance.
- R11: The page number of `ins_vaddr` and of `flush_vaddr` is the address with its low 13 offset bits removed (8 KB pages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VA_W-PAGE_W | Page number to look up |
| lk_asn | input | ASN_W | Current address-space tag |
| lk_hit | output | 1 | A slot matched |
| lk_index | output | clog2(DEPTH) | Lowest matching slot |
| lk_ppn | output | PPN_W | Physical page of the hit |
| lk_rd_en | output | MODE_N | Read permission per mode |
| lk_wr_en | output | MODE_N | Write permission per mode |
| lk_fault_rd | output | 1 | Fault-on-read flag |
| lk_fault_wr | output | 1 | Fault-on-write flag |
| lk_global | output | 1 | Shared-page flag |
| ins_valid | input | 1 | Insert request |
| ins_vaddr | input | VA_W | Virtual address being mapped |
| ins_ppn | input | PPN_W | Physical page |
| ins_asn | input | ASN_W | Address-space tag |
| ins_global | input | 1 | Shared-page flag |
| ins_rd_en | input | MODE_N | Read permission mask |
| ins_wr_en | input | MODE_N | Write permission mask |
| ins_fault_rd | input | 1 | Fault-on-read flag |
| ins_fault_wr | input | 1 | Fault-on-write flag |
| flush_cmd | input | 2 | 0 none, 1 all, 2 per-process, 3 one page |
| flush_vaddr | input | VA_W | Address for a one-page flush |
| flush_asn | input | ASN_W | Address-space tag for a one-page flush |

## Verification
The bench inserts the same page twice. If a design picked the highest matching slot, or checked for duplicates, it would return the wrong slot or the wrong physical page. A lookup of a shared page under a foreign address-space tag must hit. A design that compared the tag unconditionally would miss it, and the same mistake would make a one-page flush leave the shared slot alive. An insert is issued in the same cycle as a per-process flush; a design that let the insert through would hit on the dropped page and shift every later slot number. The table is then filled past DEPTH, so a pointer that failed to wrap, or a flush-all that left the pointer where it was, shows up as a wrong `lk_index`.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FL_NONE  = 2'd0,
    FL_ALL   = 2'd1,
    FL_LOCAL = 2'd2,
    FL_PAGE  = 2'd3
  } flush_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int DEPTH = 64,
  parameter int VPN_W = 30,
  parameter int ASN_W = 8
) (
  input  logic [DEPTH-1:0]            valid,
  input  logic [DEPTH-1:0]            glob,
  input  logic [DEPTH-1:0][VPN_W-1:0] tag,
  input  logic [DEPTH-1:0][ASN_W-1:0] asn,
  input  logic [VPN_W-1:0]            req_vpn,
  input  logic [ASN_W-1:0]            req_asn,
  output logic [DEPTH-1:0]            match
);
  function automatic logic slot_hits(input logic v, input logic g,
                                     input logic [VPN_W-1:0] t, input logic [ASN_W-1:0] a,
                                     input logic [VPN_W-1:0] q, input logic [ASN_W-1:0] qa);
    return v && (t == q) && (g || (a == qa));
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = slot_hits(valid[i], glob[i], tag[i], asn[i], req_vpn, req_asn);
  end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] match,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + IDX_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear) ptr <= '0;
    else if (advance)    ptr <= step(ptr);
  end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int DEPTH  = 64,
  parameter int VA_W   = 43,
  parameter int PAGE_W = 13,
  parameter int PPN_W  = 27,
  parameter int ASN_W  = 8,
  parameter int MODE_N = 4,
  localparam int VPN_W = VA_W - PAGE_W,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASN_W-1:0]  lk_asn,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_index,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [MODE_N-1:0] lk_rd_en,
  output logic [MODE_N-1:0] lk_wr_en,
  output logic              lk_fault_rd,
  output logic              lk_fault_wr,
  output logic              lk_global,
  input  logic              ins_valid,
  input  logic [VA_W-1:0]   ins_vaddr,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic [ASN_W-1:0]  ins_asn,
  input  logic              ins_global,
  input  logic [MODE_N-1:0] ins_rd_en,
  input  logic [MODE_N-1:0] ins_wr_en,
  input  logic              ins_fault_rd,
  input  logic              ins_fault_wr,
  input  logic [1:0]        flush_cmd,
  input  logic [VA_W-1:0]   flush_vaddr,
  input  logic [ASN_W-1:0]  flush_asn
);
  import tlb_pkg::*;

  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:PAGE_W];
  endfunction

  logic [DEPTH-1:0]             valid_q, glob_q, fr_q, fw_q;
  logic [DEPTH-1:0][VPN_W-1:0]  tag_q;
  logic [DEPTH-1:0][ASN_W-1:0]  asn_q;
  logic [DEPTH-1:0][PPN_W-1:0]  ppn_q;
  logic [DEPTH-1:0][MODE_N-1:0] rd_q, wr_q;

  flush_e           fl;
  logic             fl_all, fl_local, fl_page, ins_fire;
  logic [IDX_W-1:0] victim;
  logic [DEPTH-1:0] lk_match_vec, fl_match_vec;
  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;

  assign fl       = flush_e'(flush_cmd);
  assign fl_all   = (fl == FL_ALL);
  assign fl_local = (fl == FL_LOCAL);
  assign fl_page  = (fl == FL_PAGE);
  assign ins_fire = ins_valid && (fl == FL_NONE);

  tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
    .valid(valid_q), .glob(glob_q), .tag(tag_q), .asn(asn_q),
    .req_vpn(lk_vpn), .req_asn(lk_asn), .match(lk_match_vec));

  tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
    .valid(valid_q), .glob(glob_q), .tag(tag_q), .asn(asn_q),
    .req_vpn(page_of(flush_vaddr)), .req_asn(flush_asn), .match(fl_match_vec));

  tlb_first_hit #(.DEPTH(DEPTH)) u_first (
    .match(lk_match_vec), .any(any_hit), .idx(hit_idx));

  tlb_victim #(.DEPTH(DEPTH)) u_victim (
    .clk(clk), .rst_n(rst_n), .clear(fl_all), .advance(ins_fire), .ptr(victim));

  always_ff @(posedge clk) begin
    if (!rst_n || fl_all) valid_q <= '0;
    else if (fl_local)    valid_q <= valid_q & glob_q;
    else if (fl_page)     valid_q <= valid_q & ~fl_match_vec;
    else if (ins_fire)    valid_q[victim] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ins_fire) begin
      tag_q[victim]  <= page_of(ins_vaddr);
      ppn_q[victim]  <= ins_ppn;
      asn_q[victim]  <= ins_asn;
      glob_q[victim] <= ins_global;
      rd_q[victim]   <= ins_rd_en;
      wr_q[victim]   <= ins_wr_en;
      fr_q[victim]   <= ins_fault_rd;
      fw_q[victim]   <= ins_fault_wr;
    end
  end

  always_comb begin
    lk_hit      = any_hit;
    lk_index    = any_hit ? hit_idx : '0;
    lk_ppn      = '0;
    lk_rd_en    = '0;
    lk_wr_en    = '0;
    lk_fault_rd = 1'b0;
    lk_fault_wr = 1'b0;
    lk_global   = 1'b0;
    if (any_hit) begin
      lk_ppn      = ppn_q[hit_idx];
      lk_rd_en    = rd_q[hit_idx];
      lk_wr_en    = wr_q[hit_idx];
      lk_fault_rd = fr_q[hit_idx];
      lk_fault_wr = fw_q[hit_idx];
      lk_global   = glob_q[hit_idx];
    end
  end
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DEPTH-1:0] valid_vec,
  input logic [DEPTH-1:0] glob_vec,
  input logic [IDX_W-1:0] victim,
  input logic             ins_fire,
  input logic             ins_valid,
  input logic             fl_all,
  input logic             fl_local,
  input logic             fl_page,
  input logic [DEPTH-1:0] fl_match_vec,
  input logic [DEPTH-1:0] lk_match_vec,
  input logic             lk_hit,
  input logic [IDX_W-1:0] lk_index
);
  logic [DEPTH-1:0] below_mask;
  always_comb begin
    below_mask = '0;
    for (int i = 0; i < DEPTH; i++) below_mask[i] = (i < int'(lk_index));
  end

  a_r1_hit_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit == (|lk_match_vec));

  a_r2_insert_advances: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire && victim != IDX_W'(DEPTH - 1) |=> victim == $past(victim) + IDX_W'(1));

  a_r2_insert_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |=> valid_vec[$past(victim)]);

  a_r3_flush_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fl_all |=> valid_vec == '0 && victim == '0);

  a_r4_local_kept_global: assert property (@(posedge clk) disable iff (!rst_n)
    fl_local |=> valid_vec == ($past(valid_vec) & $past(glob_vec)));

  a_r5_page_removed: assert property (@(posedge clk) disable iff (!rst_n)
    fl_page |=> (valid_vec & $past(fl_match_vec)) == '0 &&
                valid_vec == ($past(valid_vec) & ~$past(fl_match_vec)));

  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire && victim == IDX_W'(DEPTH - 1) |=> victim == '0);

  a_r8_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_match_vec[lk_index] && (lk_match_vec & below_mask) == '0);

  a_r10_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && (fl_local || fl_page) |=> $stable(victim));
endmodule

bind tlb_assoc tlb_assoc_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_vec(valid_q), .glob_vec(glob_q),
  .victim(victim), .ins_fire(ins_fire), .ins_valid(ins_valid),
  .fl_all(fl_all), .fl_local(fl_local), .fl_page(fl_page),
  .fl_match_vec(fl_match_vec), .lk_match_vec(lk_match_vec),
  .lk_hit(lk_hit), .lk_index(lk_index));

// File: tb/tlb_assoc_tb.sv
`timescale 1ns/1ps
module tlb_assoc_tb;
  localparam int DEPTH = 8, VA_W = 43, PAGE_W = 13, PPN_W = 27, ASN_W = 8, MODE_N = 4;
  localparam int VPN_W = VA_W - PAGE_W;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [VPN_W-1:0] lk_vpn = '0;
  logic [ASN_W-1:0] lk_asn = '0;
  logic lk_hit, lk_fault_rd, lk_fault_wr, lk_global;
  logic [IDX_W-1:0] lk_index;
  logic [PPN_W-1:0] lk_ppn;
  logic [MODE_N-1:0] lk_rd_en, lk_wr_en;
  logic ins_valid = 0, ins_global = 0, ins_fault_rd = 0, ins_fault_wr = 0;
  logic [VA_W-1:0] ins_vaddr = '0, flush_vaddr = '0;
  logic [PPN_W-1:0] ins_ppn = '0;
  logic [ASN_W-1:0] ins_asn = '0, flush_asn = '0;
  logic [MODE_N-1:0] ins_rd_en = '0, ins_wr_en = '0;
  logic [1:0] flush_cmd = 2'd0;

  tlb_assoc #(.DEPTH(DEPTH), .VA_W(VA_W), .PAGE_W(PAGE_W), .PPN_W(PPN_W),
              .ASN_W(ASN_W), .MODE_N(MODE_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit),
    .lk_index(lk_index), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
    .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr), .lk_global(lk_global),
    .ins_valid(ins_valid), .ins_vaddr(ins_vaddr), .ins_ppn(ins_ppn), .ins_asn(ins_asn),
    .ins_global(ins_global), .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
    .ins_fault_rd(ins_fault_rd), .ins_fault_wr(ins_fault_wr), .flush_cmd(flush_cmd),
    .flush_vaddr(flush_vaddr), .flush_asn(flush_asn));

  // reference table
  logic m_v[DEPTH], m_g[DEPTH], m_fr[DEPTH], m_fw[DEPTH];
  logic [VPN_W-1:0] m_tag[DEPTH];
  logic [ASN_W-1:0] m_asn[DEPTH];
  logic [PPN_W-1:0] m_ppn[DEPTH];
  logic [MODE_N-1:0] m_rd[DEPTH], m_wr[DEPTH];
  int m_ptr;

  typedef struct {
    logic hit; int idx; logic [PPN_W-1:0] ppn; logic [MODE_N-1:0] rd, wr;
    logic fr, fw, g; string req;
  } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0;
  bit done = 0;

  function automatic bit ref_hit(int i, logic [VPN_W-1:0] vpn, logic [ASN_W-1:0] asn);
    return m_v[i] && m_tag[i] == vpn && (m_g[i] || m_asn[i] == asn);
  endfunction

  task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [ASN_W-1:0] asn, input string req);
    exp_t e;
    e = '{hit: 0, idx: 0, ppn: '0, rd: '0, wr: '0, fr: 0, fw: 0, g: 0, req: req};
    for (int i = DEPTH - 1; i >= 0; i--)
      if (ref_hit(i, vpn, asn))
        e = '{hit: 1, idx: i, ppn: m_ppn[i], rd: m_rd[i], wr: m_wr[i],
              fr: m_fr[i], fw: m_fw[i], g: m_g[i], req: req};
    @(negedge clk);
    lk_vpn = vpn; lk_asn = asn;
    sb.push_back(e);
  endtask

  // insert and flush may be issued together; flush wins (R10)
  task automatic cmd(input bit ins, input logic [VPN_W-1:0] vpn, input logic [ASN_W-1:0] asn,
                     input logic g, input logic [PPN_W-1:0] ppn, input logic [1:0] fc,
                     input logic [VPN_W-1:0] fvpn, input logic [ASN_W-1:0] fasn);
    @(negedge clk);
    ins_valid = ins; ins_vaddr = {vpn, 13'h1abc}; ins_asn = asn; ins_global = g;
    ins_ppn = ppn; ins_rd_en = ppn[3:0]; ins_wr_en = ppn[7:4];
    ins_fault_rd = ppn[8]; ins_fault_wr = ppn[9];
    flush_cmd = fc; flush_vaddr = {fvpn, 13'h0f0f}; flush_asn = fasn;
    if (fc == 2'd1) begin
      for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
      m_ptr = 0;
    end else if (fc == 2'd2) begin
      for (int i = 0; i < DEPTH; i++) if (!m_g[i]) m_v[i] = 0;
    end else if (fc == 2'd3) begin
      for (int i = 0; i < DEPTH; i++) if (ref_hit(i, fvpn, fasn)) m_v[i] = 0;
    end else if (ins) begin
      m_v[m_ptr] = 1; m_tag[m_ptr] = vpn; m_asn[m_ptr] = asn; m_g[m_ptr] = g;
      m_ppn[m_ptr] = ppn; m_rd[m_ptr] = ppn[3:0]; m_wr[m_ptr] = ppn[7:4];
      m_fr[m_ptr] = ppn[8]; m_fw[m_ptr] = ppn[9];
      m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
    end
    @(negedge clk);
    ins_valid = 0; flush_cmd = 2'd0;
  endtask

  task automatic insert(input logic [VPN_W-1:0] vpn, input logic [ASN_W-1:0] asn,
                        input logic g, input logic [PPN_W-1:0] ppn);
    cmd(1, vpn, asn, g, ppn, 2'd0, '0, '0);
  endtask

  // monitor: compares the design against the scoreboard
  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (lk_hit !== e.hit || int'(lk_index) != e.idx || lk_ppn !== e.ppn ||
          lk_rd_en !== e.rd || lk_wr_en !== e.wr || lk_fault_rd !== e.fr ||
          lk_fault_wr !== e.fw || lk_global !== e.g) begin
        errors++;
        $display("FAIL %s: got hit=%0b idx=%0d ppn=%h rd=%h wr=%h fr=%0b fw=%0b g=%0b exp hit=%0b idx=%0d ppn=%h rd=%h wr=%h fr=%0b fw=%0b g=%0b",
                 e.req, lk_hit, lk_index, lk_ppn, lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr, lk_global,
                 e.hit, e.idx, e.ppn, e.rd, e.wr, e.fr, e.fw, e.g);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: empty after reset
    lookup(30'h0, 8'h0, "R9");
    // R1 / R7 / R11: private page hits only under its own tag
    insert(30'h00123, 8'h01, 0, 27'h0000_3a5);
    lookup(30'h00123, 8'h01, "R1_R7_R11");
    lookup(30'h00123, 8'h02, "R1");
    // R1: shared page hits under any tag
    insert(30'h00456, 8'h01, 1, 27'h0000_2c3);
    lookup(30'h00456, 8'h77, "R1_R7");
    // R8 / R2: duplicate page goes to slot 2, lowest slot reported
    insert(30'h00123, 8'h01, 0, 27'h0000_1f0);
    lookup(30'h00123, 8'h01, "R8_R2");
    // R5: one-page flush removes both copies, leaves the shared slot
    cmd(0, '0, '0, 0, '0, 2'd3, 30'h00123, 8'h01);
    lookup(30'h00123, 8'h01, "R5");
    lookup(30'h00456, 8'h05, "R5");
    // R5: one-page flush of a shared page under a foreign tag
    insert(30'h00789, 8'h09, 1, 27'h0000_0aa);
    cmd(0, '0, '0, 0, '0, 2'd3, 30'h00789, 8'h33);
    lookup(30'h00789, 8'h09, "R5");
    // R4: per-process flush
    insert(30'h00abc, 8'h03, 0, 27'h0000_155);
    cmd(0, '0, '0, 0, '0, 2'd2, '0, '0);
    lookup(30'h00abc, 8'h03, "R4");
    lookup(30'h00456, 8'h03, "R4");
    // R10: insert with a simultaneous flush is dropped
    cmd(1, 30'h00def, 8'h04, 0, 27'h0000_0f1, 2'd2, '0, '0);
    lookup(30'h00def, 8'h04, "R10");
    // R2 / R6: fill past DEPTH so the pointer wraps
    for (int k = 0; k < DEPTH; k++) insert(30'h01000 + k, 8'h05, 0, 27'h0001_000 + k);
    for (int k = 0; k < DEPTH; k++) lookup(30'h01000 + k, 8'h05, "R2_R6");
    lookup(30'h00456, 8'h05, "R6");
    // R3: flush all, next insert lands in slot 0
    cmd(0, '0, '0, 0, '0, 2'd1, '0, '0);
    lookup(30'h01003, 8'h05, "R3");
    insert(30'h02000, 8'h06, 0, 27'h0000_3ff);
    lookup(30'h02000, 8'h06, "R3");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule